// File: doc/BRIEF.md
# Micro Channel POS Configuration Unit

This block holds the programmable option select registers of an adapter card on a Micro Channel style bus. Configuration software reads two fixed identification bytes from the first two option ports, then writes an option byte that enables the card, chooses a 16 KB memory window base, turns the on-card ROM on or off, and picks an interrupt line. The unit keeps the written bytes, decodes the option byte at offset 2, and presents the result as plain signals. A separate address-mapping fabric and interrupt router consume these signals.

Each accepted write first takes the memory/ROM mapping down for one cycle. In the next cycle the unit re-decodes the option byte. The decoded settings change only while the card-enable bit of that byte is set, and the mapping comes back only when the new settings enable the ROM. A status byte reports whether the ROM is disabled and carries a constant flag that identifies the bus variant.

Top module: `pos_cfg_unit`

## Requirements
- R1: A read at a port whose low 3 bits are 0 returns 0x8C, and at low bits 1 returns 0x50. Writes never change these values.
- R2: A read at a port whose low 3 bits are 2..7 returns the byte last accepted for that index. A write is accepted when `pos_wr` is high and the port is at or above 0x102 with low bits 2..7. The stored byte is visible from the cycle after the write edge.
- R3: A write to a port below 0x102 changes no register and does not drop `map_en`.
- R4: `card_en` equals bit 0 of the byte stored at index 2.
- R5: In the cycle after an accepted write edge, `map_en` is 0. One cycle later, `map_en` is 1 exactly when bit 0 of index 2 is 1 and bit 3 is 0.
- R6: When bit 0 of index 2 is set, bits 2:1 set `win_base`: 00 gives 0xCC000, 01 gives 0xC8000, 10 gives 0xDC000 and 11 gives 0xD8000.
- R7: When bit 0 of index 2 is set, bit 3 = 1 disables the ROM. Status bit 7 then reads 1, and it reads 0 when the ROM is enabled.
- R8: When bit 0 of index 2 is set, bits 6:4 set the interrupt. Code 000 gives `irq_valid` = 0. Codes 001..111 give `irq_num` 3, 5, 7, 10, 12, 14, 15 with `irq_valid` = 1.
- R9: While bit 0 of index 2 is clear, `win_base`, `irq_num`, `irq_valid` and status bit 7 keep their values, and `map_en` stays 0 after a write.
- R10: Status bit 3 always equals the `MCA_VARIANT` parameter (default 1). All other status bits except bit 7 read 0.
- R11: After reset, indexes 2..7 read 0, `card_en` and `map_en` are 0, `irq_valid` is 0, `win_base` is 0xD8000 and status reads 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pos_wr | input | 1 | Write strobe, one cycle per write |
| pos_port | input | 16 | Port address of the access |
| pos_wdata | input | 8 | Write data |
| pos_rdata | output | 8 | Read data for `pos_port` (combinational) |
| card_en | output | 1 | Card-enabled feedback (index 2 bit 0) |
| map_en | output | 1 | Memory window / ROM mapping enable |
| win_base | output | 20 | Decoded window base address |
| irq_num | output | 4 | Decoded interrupt line number |
| irq_valid | output | 1 | An interrupt line is selected |
| status | output | 8 | Status byte: bit 7 ROM disabled, bit 3 bus variant |

## Verification
The decoder is tried with all four window codes and all eight interrupt codes while the card is enabled. This shows that each table entry maps to a distinct output, and not just a shifted copy of the field. The same field values are then written with the enable bit cleared, which separates a decoder that is gated by the enable bit from one that always follows the byte. Writes at ports 0x00FF, 0x0100 and 0x0101 check that the address cut-off is applied to the full port value and not only to its low bits. Writes to indexes other than 2 show that any accepted write still drops and then restores the mapping.

// File: rtl/pos_cfg_pkg.sv
// Package: shared widths and decode functions for the POS configuration unit.
// Assumes a 20-bit memory address space for window bases.
package pos_cfg_pkg;

    localparam int BASE_W = 20;
    localparam int IRQ_W  = 4;

    // Map the 2-bit window field to a 16 KB window base address.
    function automatic logic [BASE_W-1:0] win_decode(input logic [1:0] code);
        logic [BASE_W-1:0] b;
        case (code)
            2'b00:   b = 20'hCC000;
            2'b01:   b = 20'hC8000;
            2'b10:   b = 20'hDC000;
            default: b = 20'hD8000;
        endcase
        return b;
    endfunction

    // Map the 3-bit interrupt field to a line number (code 0 selects none).
    function automatic logic [IRQ_W-1:0] irq_decode(input logic [2:0] code);
        logic [IRQ_W-1:0] n;
        case (code)
            3'd1:    n = 4'd3;
            3'd2:    n = 4'd5;
            3'd3:    n = 4'd7;
            3'd4:    n = 4'd10;
            3'd5:    n = 4'd12;
            3'd6:    n = 4'd14;
            3'd7:    n = 4'd15;
            default: n = 4'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pos_regfile.sv
// Module: pos_regfile
// Stores the writable option bytes (indexes FIRST_RW..NREG-1) and serves reads.
// Assumes the caller has already qualified wr_en against the port cut-off.
// Indexes below FIRST_RW return fixed identification bytes.
module pos_regfile #(
    parameter int         NREG     = 8,
    parameter int         FIRST_RW = 2,
    parameter logic [7:0] ID0      = 8'h8C,
    parameter logic [7:0] ID1      = 8'h50,
    localparam int        IDX_W    = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic [7:0]       opt_byte
);

    logic [7:0] regs [NREG];

    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_reg
            if (gi == 0) begin : g_id0
                assign regs[gi] = ID0;
            end else if (gi < FIRST_RW) begin : g_id
                assign regs[gi] = ID1;
            end else begin : g_rw
                // Latch the write data when this index is addressed.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        regs[gi] <= 8'h00;
                    else if (wr_en && (idx == IDX_W'(gi)))
                        regs[gi] <= wdata;
                end
            end
        end
    endgenerate

    // Read mux over all indexes.
    always_comb rdata = regs[idx];

    assign opt_byte = regs[FIRST_RW];

endmodule

// File: rtl/pos_decode.sv
// Module: pos_decode
// Re-decodes the option byte one cycle after each accepted write.
// Settings are frozen while the enable bit (bit 0) is clear.
// Mapping is forced off on the write cycle itself.
module pos_decode
    import pos_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_acc,
    input  logic [6:0]        opt,
    output logic              map_en,
    output logic [BASE_W-1:0] win_base,
    output logic [IRQ_W-1:0]  irq_num,
    output logic              irq_valid,
    output logic              rom_off
);

    logic upd_pend;

    // Mark that a decode is owed in the cycle after a write.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_pend <= 1'b0;
        else        upd_pend <= wr_acc;
    end

    // Mapping: drop on write, restore on decode if card and ROM are enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            map_en <= 1'b0;
        else if (wr_acc)
            map_en <= 1'b0;
        else if (upd_pend && opt[0])
            map_en <= !opt[3];
    end

    // Decoded settings: update only when decoding with the card enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_base  <= win_decode(2'b11);
            irq_num   <= '0;
            irq_valid <= 1'b0;
            rom_off   <= 1'b0;
        end else if (upd_pend && opt[0]) begin
            win_base  <= win_decode(opt[2:1]);
            irq_num   <= irq_decode(opt[6:4]);
            irq_valid <= (opt[6:4] != 3'd0);
            rom_off   <= opt[3];
        end
    end

endmodule

// File: rtl/pos_cfg_unit.sv
// Module: pos_cfg_unit (top)
// Option-select register set of an adapter card: ID bytes, option storage,
// decode of the option byte and status reporting.
// Assumes single-cycle write strobes and combinational reads.
module pos_cfg_unit
    import pos_cfg_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          NREG        = 8,
    parameter logic [15:0] OPT_FIRST   = 16'h0102,
    parameter logic [7:0]  ID0         = 8'h8C,
    parameter logic [7:0]  ID1         = 8'h50,
    parameter bit          MCA_VARIANT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pos_wr,
    input  logic [15:0]       pos_port,
    input  logic [7:0]        pos_wdata,
    output logic [7:0]        pos_rdata,
    output logic              card_en,
    output logic              map_en,
    output logic [19:0]       win_base,
    output logic [3:0]        irq_num,
    output logic              irq_valid,
    output logic [7:0]        status
);

    localparam int IDX_W    = $clog2(NREG);
    localparam int FIRST_RW = 2;

    logic [IDX_W-1:0] idx;
    logic             wr_acc;
    logic [7:0]       opt_byte;
    logic             rom_off;

    assign idx = pos_port[IDX_W-1:0];

    // Accept a write only at or above the cut-off and at a writable index.
    always_comb wr_acc = pos_wr && (pos_port >= OPT_FIRST) && (idx >= IDX_W'(FIRST_RW));

    pos_regfile #(
        .NREG(NREG), .FIRST_RW(FIRST_RW), .ID0(ID0), .ID1(ID1)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_acc), .idx(idx),
        .wdata(pos_wdata), .rdata(pos_rdata), .opt_byte(opt_byte)
    );

    pos_decode u_dec (
        .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .opt(opt_byte[6:0]),
        .map_en(map_en), .win_base(win_base), .irq_num(irq_num),
        .irq_valid(irq_valid), .rom_off(rom_off)
    );

    assign card_en = opt_byte[0];

    // Status byte: ROM-disabled flag and fixed bus-variant flag.
    always_comb status = {rom_off, 3'b000, MCA_VARIANT, 3'b000};

    logic unused_hi;
    assign unused_hi = opt_byte[7];

endmodule

// File: rtl/pos_cfg_checker.sv
// Module: pos_cfg_checker
// Temporal checks on the ports of pos_cfg_unit; bound below.
module pos_cfg_checker #(
    parameter logic [15:0] OPT_FIRST   = 16'h0102,
    parameter logic [7:0]  ID0         = 8'h8C,
    parameter logic [7:0]  ID1         = 8'h50,
    parameter bit          MCA_VARIANT = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        pos_wr,
    input logic [15:0] pos_port,
    input logic [7:0]  pos_wdata,
    input logic [7:0]  pos_rdata,
    input logic        card_en,
    input logic        map_en,
    input logic [19:0] win_base,
    input logic [3:0]  irq_num,
    input logic        irq_valid,
    input logic [7:0]  status
);

    logic acc;
    assign acc = pos_wr && (pos_port >= OPT_FIRST) && (pos_port[2:0] >= 3'd2);

    assert_id_bytes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_port[2:0] == 3'd0 |-> pos_rdata == ID0) and
        (pos_port[2:0] == 3'd1 |-> pos_rdata == ID1));

    assert_feedback_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && pos_port[2:0] == 3'd2) |=> (card_en == $past(pos_wdata[0])));

    assert_map_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !map_en);

    assert_rom_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        map_en |-> !status[7]);

    assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !card_en |=> ($stable(win_base) && $stable(irq_num) &&
                      $stable(irq_valid) && $stable(status[7])));

    assert_variant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        status[3] == MCA_VARIANT && status[6:4] == 3'd0 && status[2:0] == 3'd0);

    assert_irq_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid == (irq_num != 4'd0));

endmodule

bind pos_cfg_unit pos_cfg_checker #(
    .OPT_FIRST(OPT_FIRST), .ID0(ID0), .ID1(ID1), .MCA_VARIANT(MCA_VARIANT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pos_wr(pos_wr), .pos_port(pos_port),
    .pos_wdata(pos_wdata), .pos_rdata(pos_rdata), .card_en(card_en),
    .map_en(map_en), .win_base(win_base), .irq_num(irq_num),
    .irq_valid(irq_valid), .status(status)
);

// File: tb/pos_cfg_unit_tb.sv
module pos_cfg_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pos_wr = 1'b0;
    logic [15:0] pos_port = 16'h0100;
    logic [7:0]  pos_wdata = 8'h00;
    logic [7:0]  pos_rdata;
    logic        card_en, map_en, irq_valid;
    logic [19:0] win_base;
    logic [3:0]  irq_num;
    logic [7:0]  status;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    pos_cfg_unit u_dut (
        .clk(clk), .rst_n(rst_n), .pos_wr(pos_wr), .pos_port(pos_port),
        .pos_wdata(pos_wdata), .pos_rdata(pos_rdata), .card_en(card_en),
        .map_en(map_en), .win_base(win_base), .irq_num(irq_num),
        .irq_valid(irq_valid), .status(status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One write cycle; returns just after the capturing edge (at negedge).
    task automatic wr(input logic [15:0] p, input logic [7:0] d);
        @(negedge clk);
        pos_port = p; pos_wdata = d; pos_wr = 1'b1;
        @(negedge clk);
        pos_wr = 1'b0;
    endtask

    function automatic logic [7:0] rd(input logic [15:0] p);
        return 8'h00;
    endfunction

    task automatic read_chk(input string req, input logic [15:0] p, input logic [7:0] exp);
        pos_port = p;
        #1;
        chk(req, {24'd0, pos_rdata}, {24'd0, exp});
    endtask

    function automatic logic [19:0] exp_base(input int c);
        case (c)
            0: return 20'hCC000;
            1: return 20'hC8000;
            2: return 20'hDC000;
            default: return 20'hD8000;
        endcase
    endfunction

    function automatic logic [3:0] exp_irq(input int c);
        case (c)
            1: return 4'd3;  2: return 4'd5;  3: return 4'd7;  4: return 4'd10;
            5: return 4'd12; 6: return 4'd14; 7: return 4'd15;
            default: return 4'd0;
        endcase
    endfunction

    task automatic t_reset;   // R11
        chk("R11 card_en", card_en, 0);
        chk("R11 map_en", map_en, 0);
        chk("R11 irq_valid", irq_valid, 0);
        chk("R11 win_base", win_base, 20'hD8000);
        chk("R11 status", status, 8'h08);
        for (int i = 2; i < 8; i++) read_chk("R11 regs", 16'h0100 + 16'(i), 8'h00);
    endtask

    task automatic t_ids;   // R1
        read_chk("R1 id0", 16'h0100, 8'h8C);
        read_chk("R1 id1", 16'h0101, 8'h50);
        wr(16'h0108, 8'h11);
        wr(16'h0109, 8'h22);
        read_chk("R1 id0 after write", 16'h0100, 8'h8C);
        read_chk("R1 id1 after write", 16'h0101, 8'h50);
    endtask

    task automatic t_regs;   // R2
        for (int i = 3; i < 8; i++) wr(16'h0100 + 16'(i), 8'hA0 + 8'(i));
        for (int i = 3; i < 8; i++) read_chk("R2 readback", 16'h0100 + 16'(i), 8'hA0 + 8'(i));
        read_chk("R2 alias by low bits", 16'h010D, 8'hA5);
    endtask

    task automatic t_ignored;   // R3
        wr(16'h0102, 8'h01);          // card on, ROM on
        @(negedge clk);
        chk("R3 setup map_en", map_en, 1);
        wr(16'h0101, 8'h00);
        chk("R3 map_en kept", map_en, 1);
        wr(16'h0100, 8'h00);
        wr(16'h00FF, 8'h5A);
        read_chk("R3 reg7 unchanged", 16'h0107, 8'hA7);
        chk("R3 card_en kept", card_en, 1);
        chk("R3 map_en kept 2", map_en, 1);
    endtask

    task automatic t_base;   // R6, R4, R5
        for (int c = 0; c < 4; c++) begin
            wr(16'h0102, 8'(1 | (c << 1)));
            chk("R5 map drop", map_en, 0);
            chk("R4 card_en", card_en, 1);
            @(negedge clk);
            chk("R6 win_base", win_base, exp_base(c));
            chk("R5 map restore", map_en, 1);
        end
        wr(16'h0105, 8'h33);
        chk("R5 drop on other index", map_en, 0);
        @(negedge clk);
        chk("R5 restore on other index", map_en, 1);
    endtask

    task automatic t_irq;   // R8
        for (int c = 0; c < 8; c++) begin
            wr(16'h0102, 8'(1 | (c << 4)));
            @(negedge clk);
            chk("R8 irq_num", irq_num, exp_irq(c));
            chk("R8 irq_valid", irq_valid, c != 0);
        end
    endtask

    task automatic t_rom;   // R7
        wr(16'h0102, 8'h09);
        @(negedge clk);
        chk("R7 status7 set", status[7], 1);
        chk("R7 map off", map_en, 0);
        wr(16'h0102, 8'h01);
        @(negedge clk);
        chk("R7 status7 clear", status[7], 0);
        chk("R7 map on", map_en, 1);
    endtask

    task automatic t_freeze;   // R9, R4
        wr(16'h0102, 8'h23);          // base C8000, irq 5
        @(negedge clk);
        wr(16'h0102, 8'h7C);          // disabled, other fields
        chk("R4 card_en low", card_en, 0);
        @(negedge clk);
        chk("R9 base frozen", win_base, 20'hC8000);
        chk("R9 irq frozen", irq_num, 4'd5);
        chk("R9 valid frozen", irq_valid, 1);
        chk("R9 status7 frozen", status[7], 0);
        chk("R9 map stays off", map_en, 0);
        wr(16'h0106, 8'h00);
        @(negedge clk);
        chk("R9 map off after write", map_en, 0);
    endtask

    task automatic t_variant;   // R10
        chk("R10 status bit3", status[3], 1);
        chk("R10 other bits", {status[6:4], status[2:0]}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ids();
        t_regs();
        t_ignored();
        t_base();
        t_irq();
        t_rom();
        t_freeze();
        t_variant();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule